// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper Controller

This block regulates winding current in a three-phase bridge by chopping the source side of the active phase pair. While enable is high and the source is conducting, a digitized current-trip input ends the conduction interval. The source is then held off for a fixed number of clock cycles. During that interval the recirculation path is selected by a two-bit decay setting. It can be entirely fast, entirely slow, or a fast-decay prefix followed by slow decay for the remaining counts.

After every off interval, and after any enable edge or direction change, a blanking window of 6 or 12 cycles masks the trip input. This keeps the turn-on current spike from re-tripping the chopper. When enable is low, the source is chopped externally and a separate mode input picks fast or slow decay. An optional synchronous-rectifier gate follows the decay interval and drops as soon as zero current is reported. All inputs are taken as synchronous to the clock.

Top module: `chop_ctrl`

## Requirements
- R1: After reset, with enable low, src_on_o and blanking_o are 0. The first rising edge of en_i opens a blanking window.
- R2: When trip_i is high with en_i high, outside blanking and with no enable or direction change in that cycle, src_on_o goes low from the next cycle for exactly 96 cycles.
- R3: During the off interval, fast_decay_o is high for the first N counts and low for the rest. N is set by decay_sel_i: 2'b00 gives 0, 2'b01 gives 14, 2'b10 gives 46 and 2'b11 gives 96.
- R4: While the source is off, sink_recirc_o is high exactly when fast_decay_o is low. sink_recirc_o is always low while src_on_o is high.
- R5: When an off interval ends, blanking_o is high for 6 cycles if blank_long_i is 0 and for 12 cycles if it is 1. trip_i has no effect in that window, and src_on_o is high throughout it.
- R6: A change of en_i or dir_i outside the off interval restarts the full blanking window from the following cycle.
- R7: With sr_en_i high, sr_gate_o is high while the source is off. It drops in the same cycle zero_i is seen and stays low for the rest of that decay interval.
- R8: With en_i low outside an off interval, src_on_o is 0. ext_slow_i = 0 selects fast decay (fast_decay_o = 1, sink_recirc_o = 0), and ext_slow_i = 1 selects slow decay (sink_recirc_o = 1).
- R9: An enable edge or direction change during the off interval neither shortens nor restarts it.
- R10: After the blanking window, src_on_o is high and the block accepts a new trip, so the cycle repeats while en_i stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (oscillator count clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Current-sense comparator trip, digitized |
| zero_i | input | 1 | Zero-current detect |
| en_i | input | 1 | External enable / PWM chop input |
| dir_i | input | 1 | Rotation direction |
| decay_sel_i | input | 2 | Fast-decay share of the off interval |
| blank_long_i | input | 1 | 0: 6-cycle blank, 1: 12-cycle blank |
| sr_en_i | input | 1 | Synchronous rectification enable |
| ext_slow_i | input | 1 | Decay mode while en_i is low (1 = slow) |
| src_on_o | output | 1 | Source driver enable |
| fast_decay_o | output | 1 | Current decay is fast |
| sink_recirc_o | output | 1 | Sink drivers on for slow recirculation |
| sr_gate_o | output | 1 | Synchronous-rectifier gate enable |
| blanking_o | output | 1 | Trip input is masked |

## Verification
The directed periods trip the chopper with each of the four decay settings and both blank lengths. The measured off, fast-prefix and blank lengths separate the split points and the two window sizes. A direction toggle placed inside the off interval and another placed inside the blank window show that the first is ignored and the second restarts blanking. Pulses on the zero-current input mid-decay, and enable held low under both mode settings, cover the rectifier gate and the external-chop paths. Long random runs with trips, enable chops, direction flips and setting changes are compared cycle by cycle against a bench model of the sequence.

// File: rtl/chop_pkg.sv
// Shared types for the chopper controller.
// Assumes: only the three phases below are ever reachable.
package chop_pkg;
    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_OFF   = 2'd1,
        PH_BLANK = 2'd2
    } chop_ph_e;
endpackage

// File: rtl/chop_off_timer.sv
// Off-interval down-counter with mixed-decay split.
// Loads OFF_CNT-1 on load_i and counts to zero. fast_o marks the first
// share of the interval selected by sel_i. Assumes the caller only
// reads fast_o while the off phase is active.
module chop_off_timer #(
    parameter int OFF_CNT = 96,
    parameter int FAST_LO = 14,
    parameter int FAST_HI = 46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] sel_i,
    output logic       done_o,
    output logic       fast_o
);
    localparam int OW = $clog2(OFF_CNT + 1);

    logic [OW-1:0] cnt_q;
    logic [OW-1:0] thr;

    // Threshold: the counter stays at or above it during the fast prefix.
    always_comb begin
        unique case (sel_i)
            2'b00:   thr = OW'(OFF_CNT);
            2'b01:   thr = OW'(OFF_CNT - FAST_LO);
            2'b10:   thr = OW'(OFF_CNT - FAST_HI);
            default: thr = '0;
        endcase
    end

    assign fast_o = (cnt_q >= thr);
    assign done_o = (cnt_q == '0);

    // Counter: reload on a trip, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= OW'(OFF_CNT - 1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // R3: once slow decay is reached, fast does not come back within a period.
    a_r3_slow_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !fast_o) ##1 $stable(sel_i) |-> !fast_o);

    // R2: a fresh load is never reported as done on the next cycle.
    a_r2_load_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !done_o);
endmodule

// File: rtl/chop_blank_timer.sv
// Blanking window down-counter.
// Loads the short or long length minus one and counts to zero.
// Assumes both lengths are at least 1.
module chop_blank_timer #(
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    output logic done_o
);
    localparam int BMAX = (BLANK_LONG > BLANK_SHORT) ? BLANK_LONG : BLANK_SHORT;
    localparam int BW   = $clog2(BMAX + 1);

    logic [BW-1:0] cnt_q;
    logic [BW-1:0] len_m1;

    // Pick the window length; collapse to a constant if both are equal.
    generate
        if (BLANK_SHORT == BLANK_LONG) begin : g_fixed
            assign len_m1 = BW'(BLANK_SHORT - 1);
        end else begin : g_sel
            assign len_m1 = long_i ? BW'(BLANK_LONG - 1) : BW'(BLANK_SHORT - 1);
        end
    endgenerate

    assign done_o = (cnt_q == '0);

    // Counter: reload on a window start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= len_m1;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // R5: a counting window stays open on the following cycle.
    a_r5_count_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q > 1) |=> !done_o);
endmodule

// File: rtl/chop_drive.sv
// Decay-path output decoder and rectifier zero-current latch.
// Assumes in_off_i is high for the whole internal off interval and
// off_fast_i is valid while it is high.
module chop_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic in_off_i,
    input  logic off_fast_i,
    input  logic en_i,
    input  logic ext_slow_i,
    input  logic sr_en_i,
    input  logic zero_i,
    output logic src_on_o,
    output logic fast_o,
    output logic sink_o,
    output logic sr_o
);
    logic decay;
    logic zl_q;

    // Output decode: source, decay kind, sink recirculation, rectifier gate.
    always_comb begin
        src_on_o = en_i && !in_off_i;
        decay    = !src_on_o;
        if (in_off_i)   fast_o = off_fast_i;
        else            fast_o = !en_i && !ext_slow_i;
        sink_o   = decay && !fast_o;
        sr_o     = decay && sr_en_i && !zero_i && !zl_q;
    end

    // Zero-current latch: holds for the rest of a decay interval.
    always_ff @(posedge clk) begin
        if (!rst_n)     zl_q <= 1'b0;
        else if (decay) zl_q <= zl_q | zero_i;
        else            zl_q <= 1'b0;
    end

    // R7: after zero current within a decay, the gate stays off next cycle.
    a_r7_zero_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (decay && zero_i) ##1 decay |-> !sr_o);

    // R4: sinks never recirculate while the source conducts.
    a_r4_no_sink_with_src: assert property (@(posedge clk) disable iff (!rst_n)
        src_on_o |-> !sink_o);
endmodule

// File: rtl/chop_ctrl.sv
// Fixed off-time PWM chopper controller (top).
// Sequence: RUN (source on) -> trip -> OFF (fixed count) -> BLANK -> RUN.
// Enable edges and direction changes restart blanking outside OFF.
// Assumes all inputs are synchronous to clk.
module chop_ctrl #(
    parameter int OFF_CNT     = 96,
    parameter int FAST_LO     = 14,
    parameter int FAST_HI     = 46,
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic       zero_i,
    input  logic       en_i,
    input  logic       dir_i,
    input  logic [1:0] decay_sel_i,
    input  logic       blank_long_i,
    input  logic       sr_en_i,
    input  logic       ext_slow_i,
    output logic       src_on_o,
    output logic       fast_decay_o,
    output logic       sink_recirc_o,
    output logic       sr_gate_o,
    output logic       blanking_o
);
    import chop_pkg::*;

    chop_ph_e ph_q, ph_d;
    logic     en_q, dir_q;
    logic     evt;
    logic     off_load, blank_load;
    logic     off_done, off_fast, blank_done;

    assign evt = (en_i != en_q) || (dir_i != dir_q);

    // Next phase and timer loads.
    always_comb begin
        ph_d       = ph_q;
        off_load   = 1'b0;
        blank_load = 1'b0;
        unique case (ph_q)
            PH_RUN: begin
                if (evt) begin
                    ph_d = PH_BLANK; blank_load = 1'b1;
                end else if (trip_i && en_i) begin
                    ph_d = PH_OFF; off_load = 1'b1;
                end
            end
            PH_OFF: begin
                if (off_done) begin
                    ph_d = PH_BLANK; blank_load = 1'b1;
                end
            end
            PH_BLANK: begin
                if (evt)             blank_load = 1'b1;
                else if (blank_done) ph_d = PH_RUN;
            end
            default: ph_d = PH_RUN;
        endcase
    end

    // Phase register and input edge trackers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_RUN;
            en_q  <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            en_q  <= en_i;
            dir_q <= dir_i;
        end
    end

    chop_off_timer #(
        .OFF_CNT(OFF_CNT), .FAST_LO(FAST_LO), .FAST_HI(FAST_HI)
    ) off_i (
        .clk(clk), .rst_n(rst_n), .load_i(off_load), .sel_i(decay_sel_i),
        .done_o(off_done), .fast_o(off_fast)
    );

    chop_blank_timer #(
        .BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG)
    ) blank_i (
        .clk(clk), .rst_n(rst_n), .load_i(blank_load), .long_i(blank_long_i),
        .done_o(blank_done)
    );

    chop_drive drive_i (
        .clk(clk), .rst_n(rst_n), .in_off_i(ph_q == PH_OFF), .off_fast_i(off_fast),
        .en_i(en_i), .ext_slow_i(ext_slow_i), .sr_en_i(sr_en_i), .zero_i(zero_i),
        .src_on_o(src_on_o), .fast_o(fast_decay_o), .sink_o(sink_recirc_o),
        .sr_o(sr_gate_o)
    );

    assign blanking_o = (ph_q == PH_BLANK);

    // R9: the off phase is left only when its counter has expired.
    a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_OFF && !off_done) |=> ph_q == PH_OFF);

    // R5: a trip inside the blank window never starts an off interval.
    a_r5_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BLANK && trip_i) |=> ph_q != PH_OFF);

    // R2: an accepted trip in the run phase starts the off interval.
    a_r2_trip_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN && trip_i && en_i && !evt) |=> !src_on_o);

    // R6: an edge outside the off phase opens the blank window.
    a_r6_event_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_OFF && evt) |=> blanking_o);

    // R8: with enable low the source never conducts.
    a_r8_disabled_src_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !src_on_o);
endmodule

// File: tb/chop_ctrl_tb_top.sv
`timescale 1ns/1ps
module chop_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip = 0, zero = 0, en = 0, dir = 0, bsel = 0, sr_en = 0, xslow = 0;
    logic [1:0] dsel = 2'b00;
    logic src_on, fast, sink, srg, blank;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model state: 0 run, 1 off, 2 blank.
    int m_ph = 0, m_c = 0, m_b = 0;
    bit m_enq = 0, m_dirq = 0, m_zl = 0;

    always #2.5 clk = ~clk;

    chop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .zero_i(zero), .en_i(en),
        .dir_i(dir), .decay_sel_i(dsel), .blank_long_i(bsel), .sr_en_i(sr_en),
        .ext_slow_i(xslow), .src_on_o(src_on), .fast_decay_o(fast),
        .sink_recirc_o(sink), .sr_gate_o(srg), .blanking_o(blank)
    );

    function automatic int flen(input logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b01: return 14;
            2'b10: return 46;
            default: return 96;
        endcase
    endfunction

    function automatic int blen(input logic b);
        return b ? 12 : 6;
    endfunction

    function automatic bit e_src();
        return en && (m_ph != 1);
    endfunction

    function automatic bit e_fast();
        if (m_ph == 1) return (95 - m_c) < flen(dsel);
        return !e_src() && !xslow;
    endfunction

    task automatic chk_eq(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every output with the model, then advance one clock.
    task automatic tick();
        bit dec, evt;
        #1;
        chk_eq("R5 blanking_o", blank, (m_ph == 2));
        chk_eq("R2 src_on_o", src_on, e_src());
        chk_eq("R3 fast_decay_o", fast, e_fast());
        chk_eq("R4 sink_recirc_o", sink, !e_src() && !e_fast());
        chk_eq("R7 sr_gate_o", srg, !e_src() && sr_en && !zero && !m_zl);
        dec = !e_src();
        evt = (en != m_enq) || (dir != m_dirq);
        @(posedge clk);
        case (m_ph)
            0: if (evt) begin m_ph = 2; m_b = blen(bsel) - 1; end
               else if (trip && en) begin m_ph = 1; m_c = 95; end
            1: if (m_c == 0) begin m_ph = 2; m_b = blen(bsel) - 1; end
               else m_c--;
            default: if (evt) m_b = blen(bsel) - 1;
                     else if (m_b == 0) m_ph = 0;
                     else m_b--;
        endcase
        m_zl = dec ? (m_zl | zero) : 1'b0;
        m_enq = en;
        m_dirq = dir;
        @(negedge clk);
    endtask

    task automatic wait_run();
        int g = 0;
        while (!(src_on && !blank) && g < 300) begin tick(); g++; end
    endtask

    // Trip once and measure off, fast-prefix and blank lengths.
    task automatic period(input int poke_at, output int noff, output int nfast,
                          output int nblank);
        noff = 0; nfast = 0; nblank = 0;
        wait_run();
        trip = 1; tick(); trip = 0;
        while (!src_on && noff < 300) begin
            if (fast) nfast++;
            if (noff == poke_at) dir = ~dir;
            noff++;
            tick();
        end
        while (blank && nblank < 300) begin nblank++; tick(); end
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog expired at %0t", $time);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int no, nf, nb, g;
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk_eq("R1 src_on after reset", src_on, 0);
        chk_eq("R1 blanking after reset", blank, 0);
        en = 1; tick();
        chk_eq("R1 enable opens blank", blank, 1);

        // R3/R5/R2: each decay split with both blank lengths.
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 2; b++) begin
                dsel = s[1:0]; bsel = b[0];
                period(-1, no, nf, nb);
                chk_eq("R2 off length", no, 96);
                chk_eq("R3 fast prefix", nf, flen(s[1:0]));
                chk_eq("R5 blank length", nb, blen(b[0]));
                chk_eq("R10 source back on", src_on, 1);
            end
        end

        // R9: direction toggle inside off interval does not change it.
        dsel = 2'b01; bsel = 0;
        period(10, no, nf, nb);
        chk_eq("R9 off length with toggle", no, 96);
        chk_eq("R9 blank after toggle", nb, 6);

        // R6: direction toggle inside blank restarts the window.
        wait_run();
        trip = 1; tick(); trip = 0;
        while (!src_on) tick();
        tick(); tick();
        dir = ~dir;
        nb = 0;
        while (blank && nb < 100) begin nb++; tick(); end
        chk_eq("R6 restarted blank", nb, 7);

        // R5: trip during blank is ignored.
        wait_run();
        trip = 1; tick(); trip = 0;
        while (!src_on) tick();
        trip = 1; tick(); tick(); trip = 0;
        chk_eq("R5 trip masked in blank", src_on, 1);

        // R7: rectifier gate drops on zero current and stays low.
        sr_en = 1; dsel = 2'b00;
        wait_run();
        trip = 1; tick(); trip = 0;
        #1 chk_eq("R7 gate on in decay", srg, 1);
        tick(); tick();
        zero = 1;
        #1 chk_eq("R7 gate off at zero", srg, 0);
        tick(); zero = 0; tick();
        #1 chk_eq("R7 gate stays off", srg, 0);
        while (!src_on) tick();
        sr_en = 0;

        // R8: external chop with both decay modes.
        wait_run();
        en = 0; xslow = 0; tick();
        #1 chk_eq("R8 src off", src_on, 0);
        chk_eq("R8 fast mode", fast, 1);
        chk_eq("R8 fast no sink", sink, 0);
        xslow = 1;
        #1 chk_eq("R8 slow sink", sink, 1);
        tick(); tick();
        en = 1; tick();

        // Random mix against the model.
        for (int i = 0; i < 6000; i++) begin
            trip = ($urandom % 6) == 0;
            zero = ($urandom % 9) == 0;
            if (($urandom % 25) == 0) en = ~en;
            if (($urandom % 60) == 0) dir = ~dir;
            if (($urandom % 150) == 0) dsel = 2'($urandom);
            if (($urandom % 150) == 0) bsel = 1'($urandom);
            if (($urandom % 80) == 0) sr_en = ~sr_en;
            if (($urandom % 40) == 0) xslow = ~xslow;
            tick();
        end
        g = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule